// File: doc/BRIEF.md
# Downlink Shared-Channel Reference Symbol Pattern Generator

This block works out where the demodulation reference symbols of one downlink shared-channel allocation sit. The caller gives the allocation's timing: mapping type, start symbol and length. It also gives the reference-signal options: configuration type, the first-symbol selector for slot-based mapping, the front-loaded symbol count, the additional-position index and the number of code-division groups left without data. From these the block returns a 14-bit symbol mask over the slot and a 12-bit subcarrier mask over one resource block.

A single `start` strobe samples the request. The results are registered and appear one cycle later, together with a one-cycle `done` pulse. The outputs then hold until the next strobe. A small position table covers only a subset of durations and options. A request outside that subset, or one that is malformed, raises `err` and clears both masks.

The controller has two states. IDLE waits for a strobe. EMIT presents a fresh result with `done` high. Three transitions connect them: ACCEPT (IDLE to EMIT on a strobe), REARM (EMIT to EMIT on a strobe that arrives while a result is being presented) and RETIRE (EMIT to IDLE without a strobe).

Top module: `dmrs_pattern_gen`

## Requirements
- R1: After reset, `done` and `err` are 0 and both masks are all zeros.
- R2: A strobe on `start` at a clock edge produces `done`=1 at the next edge, with the outputs loaded from that strobe's inputs. Without a strobe, `done` returns to 0 and all other outputs hold their values.
- R3: For slot-based mapping (`map_b`=0), the first reference symbol is 3 when `pos3_sel`=1 and 2 otherwise. The table is looked up with duration `alloc_start`+`alloc_len`, and the symbol mask is absolute in the slot. Example: start 2, length 12, additional index 2, one front-loaded symbol gives symbols 2, 7 and 11 (0,5,9 relative to the start).
- R4: With one front-loaded symbol and slot-based mapping, the additional symbols are: duration 8–9 gives {7} for index≥1. Duration 10–11 gives {9} for index 1 and {6,9} for 2 or 3. Duration 12 gives {9}, {6,9} and {5,8,11} for index 1, 2 and 3. Duration 13–14 gives {11}, {7,11} and {5,8,11} for index 1, 2 and 3. Index 0 gives no additional symbols.
- R5: For mini-slot mapping (`map_b`=1), the lookup duration is `alloc_len`. The first symbol is 0 relative to the allocation, and every position is shifted by `alloc_start` into the slot. With one front-loaded symbol, lengths 2–7 are supported, and lengths 5–7 with index≥1 add relative symbol 4.
- R6: With `two_front`=1, every base position p also marks p+1. The base table is then: slot-based duration 10–14, with index 0 giving the first symbol only, and index 1 adding 8 (duration 10–12) or 10 (duration 13–14). Mini-slot lengths 5–7 are supported with index 0 only.
- R7: Configuration type 1 (`cfg_type2`=0) marks subcarriers 4n+2k'+Δ for n=0..2, k'=0..1. Δ is {0} when `cdm_free`=1, which gives 0x555. Δ is {0,1} when `cdm_free` is 2 or 3, which gives 0xFFF. Bit i of `sc_mask` is subcarrier i.
- R8: Configuration type 2 (`cfg_type2`=1) marks subcarriers 6n+k'+Δ for n=0..1, k'=0..1. Δ is {0} for `cdm_free`=1 (0x0C3), {0,2} for 2 (0x3CF) and {0,2,4} for 3 (0xFFF).
- R9: `err`=1, with both masks zero, when any of these holds: `cdm_free`=0, `alloc_start`+`alloc_len` exceeds 14, or the combination of mapping type, duration, front-load count and index is outside R4–R6. Otherwise `err`=0.
- R10: A strobe in the cycle where `done` is high is accepted. `done` stays high for one more cycle and the outputs reflect the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| cfg_type2 | input | 1 | 0: configuration type 1, 1: configuration type 2 |
| map_b | input | 1 | 0: slot-based mapping, 1: mini-slot mapping |
| alloc_start | input | 4 | First symbol of the allocation |
| alloc_len | input | 4 | Allocation length in symbols |
| pos3_sel | input | 1 | Slot-based first reference symbol at 3 instead of 2 |
| two_front | input | 1 | Two front-loaded symbols |
| add_pos | input | 2 | Additional-position index 0..3 |
| cdm_free | input | 2 | CDM groups without data, 1..3 |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Unsupported or malformed request |
| sym_mask | output | 14 | Reference symbols, bit i = slot symbol i |
| sc_mask | output | 12 | Reference subcarriers, bit i = subcarrier i |

## Verification
Two events can share a cycle: a result being presented with `done` high, and a new strobe being taken in. The bench provokes this by raising `start` again in the very cycle the previous `done` is visible. It checks that the old result is still intact in that cycle, and that the next cycle carries the new request's masks with `done` still high. Random requests also hit the overlap of an error verdict with a valid subcarrier pattern; there the cleared masks are judged against the bench model.

// File: rtl/dmrs_pkg.sv
package dmrs_pkg;
    localparam int SLOT_SYMS = 14;
    localparam int RB_SCS    = 12;
    localparam int IDX_W     = 4;

    typedef enum logic [0:0] {
        FSM_IDLE = 1'b0,
        FSM_EMIT = 1'b1
    } fsm_e;
endpackage

// File: rtl/dmrs_pos_rom.sv
module dmrs_pos_rom #(
    parameter int NSYM  = dmrs_pkg::SLOT_SYMS,
    parameter int DUR_W = dmrs_pkg::IDX_W + 1
) (
    input  logic             map_b,
    input  logic             two_front,
    input  logic [1:0]       add_pos,
    input  logic [DUR_W-1:0] dur,
    output logic [NSYM-1:0]  extra,
    output logic             hit
);
    always_comb begin
        extra = '0;
        hit   = 1'b0;
        if (!two_front) begin
            if (!map_b) begin
                if (dur >= DUR_W'(8) && dur <= DUR_W'(14)) begin
                    hit = 1'b1;
                    if (add_pos != 2'd0) begin
                        if (dur <= DUR_W'(9)) begin
                            extra[7] = 1'b1;
                        end else if (dur <= DUR_W'(11)) begin
                            extra[9] = 1'b1;
                            if (add_pos >= 2'd2) extra[6] = 1'b1;
                        end else if (dur == DUR_W'(12)) begin
                            if (add_pos == 2'd1) begin
                                extra[9] = 1'b1;
                            end else if (add_pos == 2'd2) begin
                                extra[6] = 1'b1;
                                extra[9] = 1'b1;
                            end else begin
                                extra[5]  = 1'b1;
                                extra[8]  = 1'b1;
                                extra[11] = 1'b1;
                            end
                        end else begin
                            if (add_pos == 2'd1) begin
                                extra[11] = 1'b1;
                            end else if (add_pos == 2'd2) begin
                                extra[7]  = 1'b1;
                                extra[11] = 1'b1;
                            end else begin
                                extra[5]  = 1'b1;
                                extra[8]  = 1'b1;
                                extra[11] = 1'b1;
                            end
                        end
                    end
                end
            end else begin
                if (dur >= DUR_W'(2) && dur <= DUR_W'(7)) begin
                    hit = 1'b1;
                    if (dur >= DUR_W'(5) && add_pos != 2'd0) extra[4] = 1'b1;
                end
            end
        end else begin
            if (!map_b) begin
                if (dur >= DUR_W'(10) && dur <= DUR_W'(14) && add_pos <= 2'd1) begin
                    hit = 1'b1;
                    if (add_pos == 2'd1) begin
                        if (dur <= DUR_W'(12)) extra[8]  = 1'b1;
                        else                   extra[10] = 1'b1;
                    end
                end
            end else begin
                if (dur >= DUR_W'(5) && dur <= DUR_W'(7) && add_pos == 2'd0) hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmrs_sym_builder.sv
module dmrs_sym_builder #(
    parameter int NSYM  = dmrs_pkg::SLOT_SYMS,
    parameter int IDX_W = dmrs_pkg::IDX_W
) (
    input  logic             map_b,
    input  logic             pos3_sel,
    input  logic             two_front,
    input  logic [IDX_W-1:0] alloc_start,
    input  logic [NSYM-1:0]  extra,
    output logic [NSYM-1:0]  sym
);
    logic [NSYM-1:0] base;
    logic [NSYM-1:0] placed;

    always_comb begin
        base = extra;
        if (map_b)         base[0] = 1'b1;
        else if (pos3_sel) base[3] = 1'b1;
        else               base[2] = 1'b1;
        placed = map_b ? (base << alloc_start) : base;
        sym    = two_front ? (placed | (placed << 1)) : placed;
    end
endmodule

// File: rtl/dmrs_sc_builder.sv
module dmrs_sc_builder #(
    parameter int NSC = dmrs_pkg::RB_SCS
) (
    input  logic           cfg_type2,
    input  logic [1:0]     cdm_free,
    output logic [NSC-1:0] sc
);
    localparam int T1_GROUPS = NSC / 4;
    localparam int T2_GROUPS = NSC / 6;

    always_comb begin
        sc = '0;
        if (!cfg_type2) begin
            for (int n = 0; n < T1_GROUPS; n++) begin
                for (int kp = 0; kp < 2; kp++) begin
                    sc[4*n + 2*kp] = 1'b1;
                    if (cdm_free >= 2'd2) sc[4*n + 2*kp + 1] = 1'b1;
                end
            end
        end else begin
            for (int n = 0; n < T2_GROUPS; n++) begin
                for (int kp = 0; kp < 2; kp++) begin
                    sc[6*n + kp] = 1'b1;
                    if (cdm_free >= 2'd2) sc[6*n + kp + 2] = 1'b1;
                    if (cdm_free == 2'd3) sc[6*n + kp + 4] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dmrs_pattern_gen.sv
module dmrs_pattern_gen
    import dmrs_pkg::*;
#(
    parameter int NSYM  = SLOT_SYMS,
    parameter int NSC   = RB_SCS,
    parameter int IDX_W = dmrs_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_type2,
    input  logic             map_b,
    input  logic [IDX_W-1:0] alloc_start,
    input  logic [IDX_W-1:0] alloc_len,
    input  logic             pos3_sel,
    input  logic             two_front,
    input  logic [1:0]       add_pos,
    input  logic [1:0]       cdm_free,
    output logic             done,
    output logic             err,
    output logic [NSYM-1:0]  sym_mask,
    output logic [NSC-1:0]   sc_mask
);
    localparam int DUR_W = IDX_W + 1;

    fsm_e            state_q, state_n;
    logic [DUR_W-1:0] span;
    logic [DUR_W-1:0] dur;
    logic [NSYM-1:0]  extra;
    logic             rom_hit;
    logic [NSYM-1:0]  sym_c;
    logic [NSC-1:0]   sc_c;
    logic             bad_c;

    assign span  = DUR_W'(alloc_start) + DUR_W'(alloc_len);
    assign dur   = map_b ? DUR_W'(alloc_len) : span;
    assign bad_c = !rom_hit || (cdm_free == 2'd0) || (span > DUR_W'(NSYM));

    dmrs_pos_rom #(.NSYM(NSYM), .DUR_W(DUR_W)) u_rom (
        .map_b     (map_b),
        .two_front (two_front),
        .add_pos   (add_pos),
        .dur       (dur),
        .extra     (extra),
        .hit       (rom_hit)
    );

    dmrs_sym_builder #(.NSYM(NSYM), .IDX_W(IDX_W)) u_sym (
        .map_b       (map_b),
        .pos3_sel    (pos3_sel),
        .two_front   (two_front),
        .alloc_start (alloc_start),
        .extra       (extra),
        .sym         (sym_c)
    );

    dmrs_sc_builder #(.NSC(NSC)) u_sc (
        .cfg_type2 (cfg_type2),
        .cdm_free  (cdm_free),
        .sc        (sc_c)
    );

    // Next-state: ACCEPT, REARM, RETIRE
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FSM_IDLE: state_n = start ? FSM_EMIT : FSM_IDLE;
            FSM_EMIT: state_n = start ? FSM_EMIT : FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FSM_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err      <= 1'b0;
            sym_mask <= '0;
            sc_mask  <= '0;
        end else if (start) begin
            err      <= bad_c;
            sym_mask <= bad_c ? '0 : sym_c;
            sc_mask  <= bad_c ? '0 : sc_c;
        end
    end

    assign done = (state_q == FSM_EMIT);
endmodule

// File: rtl/dmrs_pattern_gen_chk.sv
module dmrs_pattern_gen_chk #(
    parameter int NSYM = 14,
    parameter int NSC  = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            map_b,
    input logic            pos3_sel,
    input logic            two_front,
    input logic            done,
    input logic            err,
    input logic [NSYM-1:0] sym_mask,
    input logic [NSC-1:0]  sc_mask
);
    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r2_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(sym_mask) && $stable(sc_mask) && $stable(err)));

    a_r9_error_clears_masks: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (sym_mask == '0 && sc_mask == '0));

    a_r3_first_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !map_b && !pos3_sel) |=> (err || sym_mask[2]));

    a_r6_pairs_even: assert property (@(posedge clk) disable iff (!rst_n)
        (start && two_front) |=> ($countones(sym_mask) % 2 == 0));

    a_r7_sc_zero_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (sc_mask[0] && sym_mask != '0));
endmodule

bind dmrs_pattern_gen dmrs_pattern_gen_chk #(.NSYM(NSYM), .NSC(NSC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .map_b     (map_b),
    .pos3_sel  (pos3_sel),
    .two_front (two_front),
    .done      (done),
    .err       (err),
    .sym_mask  (sym_mask),
    .sc_mask   (sc_mask)
);

// File: tb/dmrs_pattern_gen_tb.sv
module dmrs_pattern_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_type2 = 1'b0, map_b = 1'b0, pos3_sel = 1'b0, two_front = 1'b0;
    logic [3:0]  alloc_start = '0, alloc_len = '0;
    logic [1:0]  add_pos = '0, cdm_free = '0;
    logic        done, err;
    logic [13:0] sym_mask;
    logic [11:0] sc_mask;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dmrs_pattern_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_type2(cfg_type2),
        .map_b(map_b), .alloc_start(alloc_start), .alloc_len(alloc_len),
        .pos3_sel(pos3_sel), .two_front(two_front), .add_pos(add_pos),
        .cdm_free(cdm_free), .done(done), .err(err),
        .sym_mask(sym_mask), .sc_mask(sc_mask)
    );

    typedef struct packed {
        logic        e;
        logic [13:0] s;
        logic [11:0] c;
    } res_t;

    // Reference model from the requirement text
    function automatic res_t model(logic t2, logic mb, logic [3:0] st, logic [3:0] ln,
                                   logic p3, logic tf, logic [1:0] ap, logic [1:0] cd);
        res_t r;
        int   d, ld;
        int   pos[4];
        int   np;
        bit   ok;
        r  = '0;
        np = 0;
        ok = 0;
        d  = int'(st) + int'(ln);
        ld = mb ? int'(ln) : d;
        pos[0] = mb ? 0 : (p3 ? 3 : 2);
        np = 1;
        if (!tf && !mb && ld >= 8 && ld <= 14) begin
            ok = 1;
            if (ap == 1) begin
                pos[1] = (ld <= 9) ? 7 : (ld <= 12) ? 9 : 11; np = 2;
            end else if (ap == 2) begin
                if (ld <= 9)       begin pos[1] = 7; np = 2; end
                else if (ld <= 12) begin pos[1] = 6; pos[2] = 9; np = 3; end
                else               begin pos[1] = 7; pos[2] = 11; np = 3; end
            end else if (ap == 3) begin
                if (ld <= 9)       begin pos[1] = 7; np = 2; end
                else if (ld <= 11) begin pos[1] = 6; pos[2] = 9; np = 3; end
                else               begin pos[1] = 5; pos[2] = 8; pos[3] = 11; np = 4; end
            end
        end else if (!tf && mb && ld >= 2 && ld <= 7) begin
            ok = 1;
            if (ld >= 5 && ap != 0) begin pos[1] = 4; np = 2; end
        end else if (tf && !mb && ld >= 10 && ld <= 14 && ap <= 1) begin
            ok = 1;
            if (ap == 1) begin pos[1] = (ld <= 12) ? 8 : 10; np = 2; end
        end else if (tf && mb && ld >= 5 && ld <= 7 && ap == 0) begin
            ok = 1;
        end
        if (!ok || cd == 0 || d > 14) begin
            r.e = 1'b1;
            return r;
        end
        for (int i = 0; i < np; i++) begin
            int p;
            p = pos[i] + (mb ? int'(st) : 0);
            r.s[p] = 1'b1;
            if (tf) r.s[p+1] = 1'b1;
        end
        if (!t2) r.c = (cd == 1) ? 12'h555 : 12'hFFF;
        else     r.c = (cd == 1) ? 12'h0C3 : (cd == 2) ? 12'h3CF : 12'hFFF;
        return r;
    endfunction

    task automatic check(string tag, logic exp_done, res_t exp);
        n_vec++;
        if (done !== exp_done || err !== exp.e || sym_mask !== exp.s || sc_mask !== exp.c) begin
            n_bad++;
            $display("FAIL %s: got done=%b err=%b sym=%h sc=%h, expected done=%b err=%b sym=%h sc=%h",
                     tag, done, err, sym_mask, sc_mask, exp_done, exp.e, exp.s, exp.c);
        end
    endtask

    task automatic drive(logic t2, logic mb, logic [3:0] st, logic [3:0] ln,
                         logic p3, logic tf, logic [1:0] ap, logic [1:0] cd);
        cfg_type2 = t2; map_b = mb; alloc_start = st; alloc_len = ln;
        pos3_sel = p3; two_front = tf; add_pos = ap; cdm_free = cd;
    endtask

    // Single request: strobe, then judge one cycle later
    task automatic run_one(string tag, logic t2, logic mb, logic [3:0] st, logic [3:0] ln,
                           logic p3, logic tf, logic [1:0] ap, logic [1:0] cd);
        res_t m;
        @(negedge clk);
        drive(t2, mb, st, ln, p3, tf, ap, cd);
        m = model(t2, mb, st, ln, p3, tf, ap, cd);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(tag, 1'b1, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        res_t m0, m1, m2, held;
        int unsigned seed;
        seed = $urandom(32'd20240126);
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0, '0);

        // R3 worked example: absolute 2,7,11; type 1 with two CDM groups -> all subcarriers
        run_one("R3 example", 0, 0, 4'd2, 4'd12, 0, 0, 2'd2, 2'd2);
        m0.e = 1'b0; m0.s = 14'h0884; m0.c = 12'hFFF;
        n_vec++;
        if (sym_mask !== m0.s || sc_mask !== m0.c) begin
            n_bad++;
            $display("FAIL R3 literal: got sym=%h sc=%h, expected sym=%h sc=%h", sym_mask, sc_mask, m0.s, m0.c);
        end
        // R2 hold and done drop
        held = model(0, 0, 4'd2, 4'd12, 0, 0, 2'd2, 2'd2);
        @(negedge clk);
        drive(1, 1, 4'd0, 4'd3, 1, 1, 2'd3, 2'd0);
        @(negedge clk);
        check("R2 hold without strobe", 1'b0, held);

        run_one("R3 pos3 first symbol", 0, 0, 4'd0, 4'd14, 1, 0, 2'd0, 2'd1);
        run_one("R4 ld12 idx3", 0, 0, 4'd1, 4'd11, 0, 0, 2'd3, 2'd1);
        run_one("R4 ld9 idx1", 0, 0, 4'd0, 4'd9, 0, 0, 2'd1, 2'd3);
        run_one("R5 mini-slot shift", 0, 1, 4'd4, 4'd7, 0, 0, 2'd1, 2'd2);
        run_one("R5 mini-slot len2", 1, 1, 4'd12, 4'd2, 0, 0, 2'd0, 2'd3);
        run_one("R6 double slot idx1", 0, 0, 4'd0, 4'd14, 1, 1, 2'd1, 2'd2);
        run_one("R6 double mini-slot", 1, 1, 4'd3, 4'd6, 0, 1, 2'd0, 2'd2);
        run_one("R7 type1 one group", 0, 0, 4'd0, 4'd10, 0, 0, 2'd0, 2'd1);
        run_one("R8 type2 one group", 1, 0, 4'd0, 4'd10, 0, 0, 2'd0, 2'd1);
        run_one("R8 type2 two groups", 1, 0, 4'd0, 4'd10, 0, 0, 2'd0, 2'd2);
        run_one("R8 type2 three groups", 1, 0, 4'd0, 4'd10, 0, 0, 2'd0, 2'd3);
        run_one("R9 zero cdm", 0, 0, 4'd2, 4'd12, 0, 0, 2'd2, 2'd0);
        run_one("R9 span past slot", 0, 1, 4'd10, 4'd6, 0, 1, 2'd0, 2'd1);
        run_one("R9 short slot-based", 0, 0, 4'd0, 4'd7, 0, 0, 2'd1, 2'd1);
        run_one("R9 double idx2", 0, 0, 4'd0, 4'd14, 0, 1, 2'd2, 2'd1);

        // R10 strobe in the done cycle
        @(negedge clk);
        drive(0, 0, 4'd0, 4'd13, 0, 0, 2'd2, 2'd1);
        m1 = model(0, 0, 4'd0, 4'd13, 0, 0, 2'd2, 2'd1);
        start = 1'b1;
        @(negedge clk);
        check("R10 first result", 1'b1, m1);
        drive(1, 1, 4'd5, 4'd5, 0, 1, 2'd0, 2'd3);
        m2 = model(1, 1, 4'd5, 4'd5, 0, 1, 2'd0, 2'd3);
        @(negedge clk);
        start = 1'b0;
        check("R10 second result", 1'b1, m2);
        @(negedge clk);
        check("R2 retire", 1'b0, m2);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic t2, mb, p3, tf;
            logic [3:0] st, ln;
            logic [1:0] ap, cd;
            t2 = 1'($urandom);
            mb = 1'($urandom);
            p3 = 1'($urandom);
            tf = 1'($urandom);
            ap = 2'($urandom);
            cd = 2'($urandom);
            st = 4'($urandom % 14);
            ln = 4'(1 + $urandom % 14);
            run_one("R4-R9 random", t2, mb, st, ln, p3, tf, ap, cd);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule